// File: doc/BRIEF.md
# DAC Output Conditioning Stage

This block sits between the serial audio receiver and the DAC datapath. It runs on the bit clock and takes a parallel pair of left and right samples, qualified by a one-cycle sample strobe. On each strobe it registers a processed copy of the pair. That copy is scaled by a per-channel attenuation word and by a shared soft-mute level. It is forced to bipolar zero (code 0 in two's complement) while the outputs are disabled.

A separate watcher counts bit-clock cycles in which both input samples are zero. When zero watching is enabled and that run reaches a long threshold, it raises a flag that tells the analog side to disconnect the output amplifier.

The attenuation model is linear. With an attenuation word `a` (0 = unity) and a mute level `m` (0 to 2^ATT_W), the effective attenuation is `t = min(a + m, 2^ATT_W)`. The output is `floor(s * (2^ATT_W - t) / 2^ATT_W)`. A level of 2^ATT_W therefore gives silence. A common-attenuation select lets the left word drive both channels.

Top module: `dac_out_ctrl`

## Requirements
- R1: After reset both sample outputs are 0, the amplifier-off flag is 0, the mute level is 0, and zero watching is inactive until `zd_en` is driven to 1.
- R2: On a cycle with `smp_stb` = 1 and `out_dis` = 0, each output register loads `floor(s * (256 - t) / 256)`, where `t = min(att + m, 256)`, `s` is the signed input sample and `m` is the mute level after that strobe's step (ATT_W = 8). Without a strobe, both outputs hold their value whatever the inputs do.
- R3: With `att_common` = 1, `att_a` sets the attenuation of both channels and `att_b` has no effect. With `att_common` = 0, `att_a` applies to left and `att_b` applies to right.
- R4: While `mute_req` = 1, each accepted strobe raises the shared mute level by exactly 1 until it reaches 256 (full silence). The same level applies to left and right.
- R5: While `mute_req` = 0, each accepted strobe lowers the mute level by 1 until it reaches 0, so the output returns gradually to its programmed gain.
- R6: While `out_dis` = 1, a strobe loads 0 into both outputs and the mute level does not change. After `out_dis` returns to 0, the next strobe resumes from the held level and settings.
- R7: With `zd_en` = 1, `amp_off` goes to 1 at the clock edge that completes ZERO_LIMIT (default 65,536) consecutive cycles in which both inputs are zero. It stays 0 at the edge before.
- R8: A cycle in which either input is nonzero clears the zero count, and `amp_off` is 0 after that edge.
- R9: The zero count saturates at ZERO_LIMIT instead of wrapping, so `amp_off` stays 1 for as long as the inputs stay zero.
- R10: With `zd_en` = 0, `amp_off` is 0 after the next edge, while the zero count keeps running. Setting `zd_en` back to 1 during an unbroken zero run raises the flag again at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_stb | input | 1 | One-cycle strobe marking a new sample pair |
| left_in | input | SMP_W | Left input sample, signed |
| right_in | input | SMP_W | Right input sample, signed |
| zd_en | input | 1 | Enable for the long-zero amplifier disconnect |
| out_dis | input | 1 | Force outputs to bipolar zero and freeze state |
| mute_req | input | 1 | Soft-mute request for both channels |
| att_common | input | 1 | Use `att_a` for both channels |
| att_a | input | ATT_W | Left (or common) attenuation, 0 = unity |
| att_b | input | ATT_W | Right attenuation |
| left_out | output | SMP_W | Processed left sample, signed |
| right_out | output | SMP_W | Processed right sample, signed |
| amp_off | output | 1 | Request to disconnect the output amplifier |

## Verification
The bench runs the mute level all the way to silence and back. A ramp that skipped, wrapped past full scale, or moved the channels apart would show up as scoreboard mismatches on individual samples. It sets an attenuation that, added to a partial mute level, goes past full scale. A missing clamp would wrap the gain and let a loud sample through. It disables the outputs in the middle of a ramp. A design that kept stepping would resume at the wrong level, and one that lost state would restart from unity. For the zero watcher, the bench samples exactly one edge before and one edge at the threshold, then holds zeros well past it and toggles the enable. This catches an off-by-one count, a counter that wraps and drops the flag, and a flag that ignores the enable.

// File: rtl/dac_oc_pkg.sv
package dac_oc_pkg;

    // Direction of the shared mute ramp in one cycle.
    typedef enum logic [1:0] {
        RAMP_HOLD = 2'd0,
        RAMP_UP   = 2'd1,
        RAMP_DOWN = 2'd2
    } ramp_dir_e;

    // Number of audio channels handled by the stage.
    localparam int NUM_CH = 2;

endpackage

// File: rtl/dac_oc_zero_watch.sv
module dac_oc_zero_watch #(
    parameter int LIMIT = 65536,
    localparam int CNT_W = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic quiet,
    input  logic enable,
    output logic flag
);

    localparam logic [CNT_W-1:0] LIM_C = CNT_W'(LIMIT);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             flag;
    } zw_state_t;

    zw_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!quiet) begin
            st_d.cnt = '0;
        end else if (st_q.cnt != LIM_C) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
        st_d.flag = enable && (st_d.cnt == LIM_C);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag = st_q.flag;

endmodule

// File: rtl/dac_oc_mute_ramp.sv
module dac_oc_mute_ramp
    import dac_oc_pkg::*;
#(
    parameter int ATT_W = 8,
    localparam int LVL_W = ATT_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_en,
    input  logic             mute_req,
    output logic [LVL_W-1:0] lvl_q,
    output logic [LVL_W-1:0] lvl_d
);

    localparam logic [LVL_W-1:0] FULL_C = {1'b1, {ATT_W{1'b0}}};

    typedef struct packed {
        logic [LVL_W-1:0] lvl;
    } mr_state_t;

    mr_state_t st_d, st_q;
    ramp_dir_e dir;

    always_comb begin
        dir = RAMP_HOLD;
        if (step_en) begin
            if (mute_req && (st_q.lvl != FULL_C)) begin
                dir = RAMP_UP;
            end else if (!mute_req && (st_q.lvl != '0)) begin
                dir = RAMP_DOWN;
            end
        end
    end

    always_comb begin
        st_d = st_q;
        case (dir)
            RAMP_UP:   st_d.lvl = st_q.lvl + LVL_W'(1);
            RAMP_DOWN: st_d.lvl = st_q.lvl - LVL_W'(1);
            default:   st_d.lvl = st_q.lvl;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lvl_q = st_q.lvl;
    assign lvl_d = st_d.lvl;

endmodule

// File: rtl/dac_oc_chan_scaler.sv
module dac_oc_chan_scaler #(
    parameter int SMP_W = 16,
    parameter int ATT_W = 8,
    localparam int LVL_W  = ATT_W + 1,
    localparam int SUM_W  = ATT_W + 2,
    localparam int PROD_W = SMP_W + ATT_W + 2
) (
    input  logic signed [SMP_W-1:0] smp,
    input  logic        [ATT_W-1:0] att,
    input  logic        [LVL_W-1:0] lvl,
    output logic signed [SMP_W-1:0] scaled
);

    localparam logic [LVL_W-1:0] FULL_C = {1'b1, {ATT_W{1'b0}}};
    localparam logic [SUM_W-1:0] FULL_S = {2'b01, {ATT_W{1'b0}}};

    logic        [SUM_W-1:0]  sum;
    logic        [LVL_W-1:0]  total;
    logic        [LVL_W-1:0]  gain;
    logic signed [PROD_W-1:0] smp_ext;
    logic signed [PROD_W-1:0] gain_ext;
    logic signed [PROD_W-1:0] prod;

    always_comb begin
        sum      = {2'b00, att} + {1'b0, lvl};
        total    = (sum > FULL_S) ? FULL_C : sum[LVL_W-1:0];
        gain     = FULL_C - total;
        smp_ext  = {{(ATT_W + 2){smp[SMP_W-1]}}, smp};
        gain_ext = $signed({{(SMP_W + 1){1'b0}}, gain});
        prod     = smp_ext * gain_ext;
        scaled   = SMP_W'(prod >>> ATT_W);
    end

endmodule

// File: rtl/dac_out_ctrl.sv
module dac_out_ctrl
    import dac_oc_pkg::*;
#(
    parameter int SMP_W      = 16,
    parameter int ATT_W      = 8,
    parameter int ZERO_LIMIT = 65536,
    localparam int LVL_W = ATT_W + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    smp_stb,
    input  logic signed [SMP_W-1:0] left_in,
    input  logic signed [SMP_W-1:0] right_in,
    input  logic                    zd_en,
    input  logic                    out_dis,
    input  logic                    mute_req,
    input  logic                    att_common,
    input  logic        [ATT_W-1:0] att_a,
    input  logic        [ATT_W-1:0] att_b,
    output logic signed [SMP_W-1:0] left_out,
    output logic signed [SMP_W-1:0] right_out,
    output logic                    amp_off
);

    // Zero watcher
    logic quiet;
    assign quiet = (left_in == '0) && (right_in == '0);

    dac_oc_zero_watch #(.LIMIT(ZERO_LIMIT)) u_zero (
        .clk    (clk),
        .rst_n  (rst_n),
        .quiet  (quiet),
        .enable (zd_en),
        .flag   (amp_off)
    );

    // Shared mute ramp, frozen while outputs are disabled
    logic             step_en;
    logic [LVL_W-1:0] mute_lvl;
    logic [LVL_W-1:0] lvl_next;
    assign step_en = smp_stb && !out_dis;

    dac_oc_mute_ramp #(.ATT_W(ATT_W)) u_ramp (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_en  (step_en),
        .mute_req (mute_req),
        .lvl_q    (mute_lvl),
        .lvl_d    (lvl_next)
    );

    // Per-channel scaling
    logic signed [SMP_W-1:0] smp_in  [NUM_CH];
    logic        [ATT_W-1:0] att_sel [NUM_CH];
    logic signed [SMP_W-1:0] scaled  [NUM_CH];

    assign smp_in[0]  = left_in;
    assign smp_in[1]  = right_in;
    assign att_sel[0] = att_a;
    assign att_sel[1] = att_common ? att_a : att_b;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        dac_oc_chan_scaler #(.SMP_W(SMP_W), .ATT_W(ATT_W)) u_scale (
            .smp    (smp_in[ch]),
            .att    (att_sel[ch]),
            .lvl    (lvl_next),
            .scaled (scaled[ch])
        );
    end

    // Output registers
    typedef struct packed {
        logic signed [SMP_W-1:0] l;
        logic signed [SMP_W-1:0] r;
    } out_state_t;

    out_state_t out_d, out_q;

    always_comb begin
        out_d = out_q;
        if (smp_stb) begin
            if (out_dis) begin
                out_d.l = '0;
                out_d.r = '0;
            end else begin
                out_d.l = scaled[0];
                out_d.r = scaled[1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign left_out  = out_q.l;
    assign right_out = out_q.r;

endmodule

// File: rtl/dac_out_ctrl_chk.sv
module dac_out_ctrl_chk #(
    parameter int SMP_W = 16,
    parameter int ATT_W = 8,
    localparam int LVL_W = ATT_W + 1
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    smp_stb,
    input logic signed [SMP_W-1:0] left_in,
    input logic signed [SMP_W-1:0] right_in,
    input logic                    zd_en,
    input logic                    out_dis,
    input logic                    mute_req,
    input logic signed [SMP_W-1:0] left_out,
    input logic signed [SMP_W-1:0] right_out,
    input logic                    amp_off,
    input logic        [LVL_W-1:0] mute_lvl
);

    localparam logic [LVL_W-1:0] FULL_C = {1'b1, {ATT_W{1'b0}}};

    a_r2_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_stb |=> ($stable(left_out) && $stable(right_out)));

    a_r4_ramp_up_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_stb && !out_dis && mute_req && (mute_lvl != FULL_C))
        |=> (mute_lvl == $past(mute_lvl) + LVL_W'(1)));

    a_r5_ramp_down_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_stb && !out_dis && !mute_req && (mute_lvl != '0))
        |=> (mute_lvl == $past(mute_lvl) - LVL_W'(1)));

    a_r6_midscale_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_stb && out_dis) |=> ((left_out == '0) && (right_out == '0)));

    a_r6_level_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        out_dis |=> (mute_lvl == $past(mute_lvl)));

    a_r8_nonzero_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ((left_in != '0) || (right_in != '0)) |=> !amp_off);

    a_r9_flag_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        (amp_off && zd_en && (left_in == '0) && (right_in == '0)) |=> amp_off);

    a_r10_enable_gates: assert property (@(posedge clk) disable iff (!rst_n)
        !zd_en |=> !amp_off);

endmodule

bind dac_out_ctrl dac_out_ctrl_chk #(.SMP_W(SMP_W), .ATT_W(ATT_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_stb   (smp_stb),
    .left_in   (left_in),
    .right_in  (right_in),
    .zd_en     (zd_en),
    .out_dis   (out_dis),
    .mute_req  (mute_req),
    .left_out  (left_out),
    .right_out (right_out),
    .amp_off   (amp_off),
    .mute_lvl  (mute_lvl)
);

// File: tb/dac_out_ctrl_tb_top.sv
`timescale 1ns/1ps
module dac_out_ctrl_tb_top;

    localparam int SMP_W = 16;
    localparam int ATT_W = 8;
    localparam int ZERO_LIMIT = 65536;
    localparam int FULL = 1 << ATT_W;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    smp_stb = 1'b0;
    logic signed [SMP_W-1:0] left_in = '0;
    logic signed [SMP_W-1:0] right_in = '0;
    logic                    zd_en = 1'b0;
    logic                    out_dis = 1'b0;
    logic                    mute_req = 1'b0;
    logic                    att_common = 1'b0;
    logic        [ATT_W-1:0] att_a = '0;
    logic        [ATT_W-1:0] att_b = '0;
    logic signed [SMP_W-1:0] left_out;
    logic signed [SMP_W-1:0] right_out;
    logic                    amp_off;

    always #2.5 clk = ~clk;

    dac_out_ctrl #(.SMP_W(SMP_W), .ATT_W(ATT_W), .ZERO_LIMIT(ZERO_LIMIT)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .smp_stb    (smp_stb),
        .left_in    (left_in),
        .right_in   (right_in),
        .zd_en      (zd_en),
        .out_dis    (out_dis),
        .mute_req   (mute_req),
        .att_common (att_common),
        .att_a      (att_a),
        .att_b      (att_b),
        .left_out   (left_out),
        .right_out  (right_out),
        .amp_off    (amp_off)
    );

    typedef struct {
        int    l;
        int    r;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fail = 0;
    int   m_model = 0;
    int   last_l = 0;
    int   last_r = 0;
    logic stb_seen = 1'b0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int scale(input int s, input int att, input int lvl);
        int     tot;
        longint p;
        tot = att + lvl;
        if (tot > FULL) tot = FULL;
        p = longint'(s) * longint'(FULL - tot);
        return int'(p >>> ATT_W);
    endfunction

    // Driver: one strobe per call, pushes the expected pair
    task automatic send(input int l, input int r, input string tag);
        exp_t e;
        int   ar;
        @(negedge clk);
        left_in  = SMP_W'(l);
        right_in = SMP_W'(r);
        smp_stb  = 1'b1;
        if (!out_dis) begin
            if (mute_req && m_model < FULL) m_model++;
            else if (!mute_req && m_model > 0) m_model--;
        end
        ar = att_common ? int'(att_a) : int'(att_b);
        e.tag = tag;
        if (out_dis) begin
            e.l = 0;
            e.r = 0;
        end else begin
            e.l = scale(l, int'(att_a), m_model);
            e.r = scale(r, ar, m_model);
        end
        last_l = e.l;
        last_r = e.r;
        exp_q.push_back(e);
        @(negedge clk);
        smp_stb = 1'b0;
    endtask

    // Monitor: compares one result after each strobed edge
    always @(posedge clk) stb_seen <= smp_stb;

    always @(negedge clk) begin
        if (stb_seen) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "scoreboard underflow", 0, 1);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(int'(left_out) == e.l, {e.tag, " left"}, int'(left_out), e.l);
                check(int'(right_out) == e.r, {e.tag, " right"}, int'(right_out), e.r);
            end
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(left_out == '0 && right_out == '0, "R1 outputs in reset", int'(left_out), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!amp_off, "R1 flag after reset", int'(amp_off), 0);
        check(left_out == '0, "R1 left after reset", int'(left_out), 0);

        // R2: unity and individual attenuation
        send(1000, -1000, "R2 unity");
        send(32767, -32768, "R2 unity extremes");
        send(-1, 1, "R2 unity small");
        att_a = 8'd64;
        att_b = 8'd128;
        send(1001, -1001, "R2 per-channel att");
        send(-32768, 32767, "R2 per-channel att extremes");
        send(-3, 3, "R2 negative floor");

        // R2: hold without strobe
        left_in  = 16'sd12345;
        right_in = -16'sd4321;
        repeat (3) @(negedge clk);
        check(int'(left_out) == last_l, "R2 hold left", int'(left_out), last_l);
        check(int'(right_out) == last_r, "R2 hold right", int'(right_out), last_r);

        // R3: common attenuation, second word ignored
        att_common = 1'b1;
        att_a = 8'd32;
        att_b = 8'd250;
        send(20000, 20000, "R3 common");
        att_b = 8'd0;
        send(20000, 20000, "R3 second word ignored");
        send(-777, 5555, "R3 common mixed");

        // R4: ramp to full mute on both channels
        att_common = 1'b0;
        att_a = '0;
        att_b = '0;
        mute_req = 1'b1;
        for (int i = 0; i < 260; i++) send(12000, -7000, "R4 mute ramp");
        check(left_out == '0 && right_out == '0, "R4 full silence", int'(left_out), 0);

        // R5: release ramp
        mute_req = 1'b0;
        for (int i = 0; i < 130; i++) send(12000, -7000, "R5 release ramp");

        // R6: disable mid-ramp, state frozen, resume
        out_dis = 1'b1;
        mute_req = 1'b1;
        for (int i = 0; i < 20; i++) send(30000, -30000, "R6 midscale");
        check(left_out == '0 && right_out == '0, "R6 midscale held", int'(left_out), 0);
        out_dis = 1'b0;
        mute_req = 1'b0;
        for (int i = 0; i < 10; i++) send(12000, -7000, "R6 resume level");

        // R2: attenuation plus mute past full scale clamps to silence
        att_common = 1'b1;
        att_a = 8'd200;
        for (int i = 0; i < 3; i++) send(32767, -32768, "R2 clamp");
        att_common = 1'b0;
        att_a = '0;
        for (int i = 0; i < 120; i++) send(9000, -9000, "R5 return to unity");
        check(int'(left_out) == 9000, "R5 unity restored", int'(left_out), 9000);

        // R7: threshold edge
        @(negedge clk);
        zd_en = 1'b1;
        left_in = 16'sd7;
        right_in = '0;
        @(negedge clk);
        left_in = '0;
        repeat (ZERO_LIMIT - 1) @(negedge clk);
        check(!amp_off, "R7 one edge before limit", int'(amp_off), 0);
        @(negedge clk);
        check(amp_off, "R7 at limit", int'(amp_off), 1);

        // R9: saturation keeps the flag
        repeat (100) @(negedge clk);
        check(amp_off, "R9 saturated", int'(amp_off), 1);

        // R10: enable gating
        zd_en = 1'b0;
        @(negedge clk);
        check(!amp_off, "R10 disabled", int'(amp_off), 0);
        zd_en = 1'b1;
        @(negedge clk);
        check(amp_off, "R10 re-enabled", int'(amp_off), 1);

        // R8: nonzero sample clears
        right_in = 16'sd1;
        @(negedge clk);
        check(!amp_off, "R8 cleared", int'(amp_off), 0);
        right_in = '0;
        repeat (5) @(negedge clk);
        check(!amp_off, "R8 recount", int'(amp_off), 0);

        check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule